// File: doc/BRIEF.md
# Clock-Synchronous Serial Receiver with Parity

This block takes in characters over a three-wire clocked serial link made of a shift clock line, a data input and a data output. Each character carries 7 or 8 data bits, sent least significant bit first. An optional parity bit follows the data. The shift clock can come from a partner device (slave mode). It can also be produced by the block itself (master mode). In master mode a dummy byte written to the transmit slot starts one character's worth of clock pulses and is shifted out on the data output. At the same time the data input is captured.

The incoming clock and data are brought into the system clock domain through two-stage synchronisers. Data is sampled on rising shift-clock edges. Software reaches the block through a small register bus with four addresses: configuration, clock divider, transmit/status and receive buffer. Completion of each character is signalled by a one-cycle interrupt pulse.

Top module: `sync_serial_rx`

## Requirements
- R1: After reset the status register reads 0, the receive buffer reads 0x00, the shift clock output and data output are high, and the interrupt is low.
- R2: Data bits arrive least significant first. Received bit k lands in receive-buffer bit k. Configuration address 0 has these fields: bit0 receive enable, bit1 transmit enable, bit2 internal clock, bit3 8-bit length (0 selects 7 bits), bit4 parity enable, bit5 odd parity.
- R3: With 7-bit length, bit 7 of the receive buffer (address 3) reads 0, even when the line bit after the data (the parity bit) is 1.
- R4: With parity enabled, one parity bit is sampled after the last data bit. For even parity the data ones plus the parity bit must be even; for odd parity they must be odd. A mismatch sets a sticky parity-error flag (status bit 2), which a read of address 3 clears.
- R5: The busy flag (status bit 0, status read at address 2) rises at the first falling shift-clock edge of a character. It falls when the last bit, including any parity bit, has been sampled.
- R6: The buffer-full flag (status bit 1) is set when a character completes and cleared by a read of address 3.
- R7: Each completed character raises the interrupt output for exactly one system clock.
- R8: If a character completes while buffer-full is set and the buffer is not being read, the buffer is overwritten and a sticky overrun flag (status bit 3) is set, cleared by a read of address 3.
- R9: In master mode (internal clock, receive and transmit enabled), a write to address 2 drives exactly one shift-clock pulse per character bit. Each half period lasts N = divider (address 1) + 1 system clocks. The clock output enable is high.
- R10: In master mode the written byte, followed by its parity bit when parity is enabled, is shifted out least significant first. Looped back to the data input, it is received unchanged with no parity error.
- R11: A write to address 2 produces no shift clock unless internal clock, receive enable and transmit enable are all set.
- R12: With receive disabled, external shift-clock activity leaves busy, buffer-full and the interrupt at 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_wr | input | 1 | Register write strobe |
| bus_rd | input | 1 | Register read strobe (read side effects) |
| bus_addr | input | 2 | Register address |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data for bus_addr |
| sclk_in | input | 1 | Shift clock from partner (slave mode) |
| sclk_out | output | 1 | Generated shift clock, idle high |
| sclk_oe | output | 1 | High when the block drives the shift clock |
| sdata_in | input | 1 | Serial data input |
| sdata_out | output | 1 | Serial data output, idle high |
| irq | output | 1 | One-cycle character-complete pulse |

## Verification
The assertions assume that serial data is stable around each rising shift-clock edge for longer than the synchroniser delay. They also assume the configuration does not change while a character is in flight. The bench drives slave-mode data at each falling edge and holds every shift-clock level for six system clocks. Master-mode runs use a divider that gives five-clock half periods. Configuration writes happen only between characters, and buffer reads are issued only after the final rising edge has passed through the synchronisers.

// File: rtl/ssr_pkg.sv
package ssr_pkg;

    typedef struct packed {
        logic par_odd;   // bit5
        logic par_en;    // bit4
        logic len8;      // bit3
        logic int_clk;   // bit2
        logic tx_en;     // bit1
        logic rx_en;     // bit0
    } cfg_t;

    typedef struct packed {
        logic ovr;       // bit3
        logic perr;      // bit2
        logic full;      // bit1
        logic busy;      // bit0
    } stat_t;

    localparam logic [1:0] A_CFG  = 2'd0;
    localparam logic [1:0] A_DIV  = 2'd1;
    localparam logic [1:0] A_TXST = 2'd2;
    localparam logic [1:0] A_RXB  = 2'd3;

    // parity bit a sender attaches to the data
    function automatic logic par_of(input logic [7:0] d, input logic len8, input logic odd);
        logic [7:0] m;
        m = len8 ? d : {1'b0, d[6:0]};
        return (^m) ^ odd;
    endfunction

    function automatic logic [3:0] frame_bits(input cfg_t c);
        return (c.len8 ? 4'd8 : 4'd7) + {3'd0, c.par_en};
    endfunction

endpackage

// File: rtl/ssr_sync.sv
module ssr_sync #(
    parameter int   STAGES  = 2,
    parameter logic RST_VAL = 1'b1
) (
    input  logic clk,
    input  logic rst,
    input  logic d,
    output logic q
);
    logic [STAGES-1:0] sr;

    always_ff @(posedge clk) begin
        if (rst) sr <= {STAGES{RST_VAL}};
        else     sr <= {sr[STAGES-2:0], d};
    end

    assign q = sr[STAGES-1];
endmodule

// File: rtl/ssr_mastergen.sv
module ssr_mastergen #(
    parameter int DIV_W = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             start,
    input  logic [DIV_W-1:0] div,
    input  logic [8:0]       frame,
    input  logic [3:0]       nbits,
    output logic             sclk,
    output logic             sdo,
    output logic             active
);
    logic [DIV_W-1:0] cnt;
    logic [4:0]       edges;
    logic [8:0]       sh;

    always_ff @(posedge clk) begin
        if (rst) begin
            sclk <= 1'b1; sdo <= 1'b1; active <= 1'b0;
            cnt <= '0; edges <= '0; sh <= '0;
        end else if (start) begin
            active <= 1'b1;
            sclk   <= 1'b0;
            cnt    <= div;
            edges  <= 5'd1;
            sdo    <= frame[0];
            sh     <= frame >> 1;
        end else if (active) begin
            if (cnt == '0) begin
                cnt   <= div;
                sclk  <= ~sclk;
                edges <= edges + 5'd1;
                if (sclk) begin
                    sdo <= sh[0];
                    sh  <= sh >> 1;
                end
                if (edges + 5'd1 == {nbits, 1'b0}) begin
                    active <= 1'b0;
                    sdo    <= 1'b1;
                end
            end else begin
                cnt <= cnt - 1'b1;
            end
        end
    end
endmodule

// File: rtl/ssr_shift.sv
module ssr_shift
    import ssr_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  cfg_t       cfg,
    input  logic       fall,
    input  logic       rise,
    input  logic       sd,
    output logic       busy,
    output logic       done,
    output logic [7:0] data,
    output logic       perr
);
    logic [7:0] data_q, data_nx;
    logic       pbit_q, pbit_nx;
    logic [3:0] idx;
    logic [3:0] dlen, nbits;

    assign dlen  = cfg.len8 ? 4'd8 : 4'd7;
    assign nbits = frame_bits(cfg);

    always_comb begin
        data_nx = data_q;
        pbit_nx = pbit_q;
        if (idx < dlen) data_nx[idx[2:0]] = sd;
        else            pbit_nx = sd;
    end

    assign done = busy && rise && (idx == nbits - 4'd1);
    assign data = cfg.len8 ? data_nx : {1'b0, data_nx[6:0]};
    assign perr = cfg.par_en && (pbit_nx != par_of(data_nx, cfg.len8, cfg.par_odd));

    always_ff @(posedge clk) begin
        if (rst) begin
            busy <= 1'b0; idx <= '0; data_q <= '0; pbit_q <= 1'b0;
        end else if (!busy) begin
            if (fall && cfg.rx_en) begin
                busy   <= 1'b1;
                idx    <= '0;
                data_q <= '0;
                pbit_q <= 1'b0;
            end
        end else if (rise) begin
            data_q <= data_nx;
            pbit_q <= pbit_nx;
            idx    <= idx + 4'd1;
            if (done) busy <= 1'b0;
        end
    end
endmodule

// File: rtl/sync_serial_rx.sv
module sync_serial_rx
    import ssr_pkg::*;
#(
    parameter int DIV_W = 8
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       bus_wr,
    input  logic       bus_rd,
    input  logic [1:0] bus_addr,
    input  logic [7:0] bus_wdata,
    output logic [7:0] bus_rdata,
    input  logic       sclk_in,
    output logic       sclk_out,
    output logic       sclk_oe,
    input  logic       sdata_in,
    output logic       sdata_out,
    output logic       irq
);
    cfg_t             cfg;
    logic [DIV_W-1:0] div_q;
    logic [7:0]       rxbuf;
    stat_t            st;

    logic sclk_s, sclk_s_d, sd_s;
    logic gclk_d, gen_active;
    logic fall, rise, busy, done, perr;
    logic [7:0] rdata_nx;
    logic start, rd_clr;
    logic [8:0] tx_frame;

    ssr_sync #(.STAGES(2), .RST_VAL(1'b1)) u_sync_clk (
        .clk(clk), .rst(rst), .d(sclk_in), .q(sclk_s));
    ssr_sync #(.STAGES(2), .RST_VAL(1'b1)) u_sync_dat (
        .clk(clk), .rst(rst), .d(sdata_in), .q(sd_s));

    always_ff @(posedge clk) begin
        if (rst) begin
            sclk_s_d <= 1'b1;
            gclk_d   <= 1'b1;
        end else begin
            sclk_s_d <= sclk_s;
            gclk_d   <= sclk_out;
        end
    end

    // edge source chosen by clock mode
    assign fall = cfg.int_clk ? (gclk_d & ~sclk_out) : (sclk_s_d & ~sclk_s);
    assign rise = cfg.int_clk ? (~gclk_d & sclk_out) : (~sclk_s_d & sclk_s);

    assign start  = bus_wr && (bus_addr == A_TXST) && cfg.int_clk && cfg.rx_en
                    && cfg.tx_en && !gen_active && !busy;
    assign rd_clr = bus_rd && (bus_addr == A_RXB);

    always_comb begin
        tx_frame = cfg.len8 ? {par_of(bus_wdata, 1'b1, cfg.par_odd), bus_wdata}
                            : {1'b1, par_of(bus_wdata, 1'b0, cfg.par_odd), bus_wdata[6:0]};
    end

    ssr_mastergen #(.DIV_W(DIV_W)) u_gen (
        .clk(clk), .rst(rst), .start(start), .div(div_q), .frame(tx_frame),
        .nbits(frame_bits(cfg)), .sclk(sclk_out), .sdo(sdata_out), .active(gen_active));

    ssr_shift u_shift (
        .clk(clk), .rst(rst), .cfg(cfg), .fall(fall), .rise(rise), .sd(sd_s),
        .busy(busy), .done(done), .data(rdata_nx), .perr(perr));

    assign sclk_oe = cfg.int_clk;

    always_ff @(posedge clk) begin
        if (rst) begin
            cfg <= '0; div_q <= '0; rxbuf <= '0;
            st.full <= 1'b0; st.perr <= 1'b0; st.ovr <= 1'b0;
            irq <= 1'b0;
        end else begin
            irq <= done;
            if (bus_wr && bus_addr == A_CFG) cfg   <= cfg_t'(bus_wdata[5:0]);
            if (bus_wr && bus_addr == A_DIV) div_q <= DIV_W'(bus_wdata);
            if (rd_clr) begin
                st.full <= 1'b0; st.perr <= 1'b0; st.ovr <= 1'b0;
            end
            if (done) begin
                rxbuf   <= rdata_nx;
                st.full <= 1'b1;
                if (perr) st.perr <= 1'b1;
                if (st.full && !rd_clr) st.ovr <= 1'b1;
            end
        end
    end

    assign st.busy = busy;

    always_comb begin
        case (bus_addr)
            A_CFG:   bus_rdata = {2'b00, cfg};
            A_DIV:   bus_rdata = 8'(div_q);
            A_TXST:  bus_rdata = {4'b0000, st};
            default: bus_rdata = rxbuf;
        endcase
    end
endmodule

// File: rtl/sync_serial_rx_chk.sv
module sync_serial_rx_chk (
    input logic clk,
    input logic rst,
    input logic irq,
    input logic full,
    input logic busy,
    input logic gen_active,
    input logic sclk_out,
    input logic rd_clr,
    input logic len8,
    input logic rxbuf_b7
);
    // R7
    irq_single_chk: assert property (@(posedge clk) disable iff (rst) irq |=> !irq);
    // R6
    irq_full_chk: assert property (@(posedge clk) disable iff (rst) irq |-> full);
    // R5
    irq_idle_chk: assert property (@(posedge clk) disable iff (rst) irq |-> !busy);
    // R6
    rd_clear_chk: assert property (@(posedge clk) disable iff (rst) rd_clr |=> (irq || !full));
    // R9
    sclk_idle_chk: assert property (@(posedge clk) disable iff (rst) !gen_active |-> sclk_out);
    // R3
    b7_zero_chk: assert property (@(posedge clk) disable iff (rst) (irq && !len8) |-> !rxbuf_b7);
endmodule

bind sync_serial_rx sync_serial_rx_chk u_chk (
    .clk(clk), .rst(rst), .irq(irq), .full(st.full), .busy(busy),
    .gen_active(gen_active), .sclk_out(sclk_out), .rd_clr(rd_clr),
    .len8(cfg.len8), .rxbuf_b7(rxbuf[7]));

// File: tb/tb_sync_serial_rx.sv
module tb_sync_serial_rx;
    logic clk = 1'b0;
    logic rst = 1'b1;
    logic bus_wr = 1'b0, bus_rd = 1'b0;
    logic [1:0] bus_addr = 2'd0;
    logic [7:0] bus_wdata = 8'd0;
    logic [7:0] bus_rdata;
    logic sclk_in = 1'b1, sd_drv = 1'b1, loopb = 1'b0;
    logic sclk_out, sclk_oe, sdata_out, irq;
    logic sdata_in;

    int tests = 0, fails = 0;
    int irq_cnt = 0, low_cnt = 0, fall_cnt = 0;
    logic sclk_prev = 1'b1;

    localparam int H = 6;

    assign sdata_in = loopb ? sdata_out : sd_drv;

    always #5 clk = ~clk;

    sync_serial_rx dut (
        .clk(clk), .rst(rst), .bus_wr(bus_wr), .bus_rd(bus_rd), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .sclk_in(sclk_in),
        .sclk_out(sclk_out), .sclk_oe(sclk_oe), .sdata_in(sdata_in),
        .sdata_out(sdata_out), .irq(irq));

    always @(negedge clk) begin
        if (irq) irq_cnt++;
        if (!sclk_out) low_cnt++;
        if (sclk_prev && !sclk_out) fall_cnt++;
        sclk_prev = sclk_out;
    end

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        tests++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [1:0] a, input logic [7:0] v);
        @(negedge clk); bus_addr = a; bus_wdata = v; bus_wr = 1'b1;
        @(negedge clk); bus_wr = 1'b0;
    endtask

    task automatic rd(input logic [1:0] a, output logic [7:0] v);
        @(negedge clk); bus_addr = a; bus_rd = 1'b1;
        #1 v = bus_rdata;
        @(negedge clk); bus_rd = 1'b0;
    endtask

    task automatic ext_send(input logic [8:0] bits, input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk); sclk_in = 1'b0; sd_drv = bits[i];
            repeat (H) @(negedge clk);
            sclk_in = 1'b1;
            repeat (H - 1) @(negedge clk);
        end
        sd_drv = 1'b1;
        repeat (8) @(negedge clk);
    endtask

    task automatic t_reset();
        logic [7:0] v;
        rd(2'd2, v); check(v == 8'h00, "R1 status", v, 0);
        rd(2'd3, v); check(v == 8'h00, "R1 rxbuf", v, 0);
        check(sclk_out && sdata_out && !irq, "R1 pins", {sclk_out, sdata_out, irq}, 3'b110);
    endtask

    task automatic t_lsb_first();
        logic [7:0] v; int i0;
        wr(2'd0, 8'h09);
        i0 = irq_cnt;
        ext_send({1'b0, 8'h1D}, 8);
        rd(2'd3, v); check(v == 8'h1D, "R2 lsb-first data", v, 8'h1D);
        check(irq_cnt == i0 + 1, "R7 one irq", irq_cnt - i0, 1);
        rd(2'd2, v); check(v == 8'h00, "R6 full cleared by read", v, 0);
    endtask

    task automatic t_busy();
        logic [7:0] v, vb;
        wr(2'd0, 8'h19);
        rd(2'd2, v); check(v[0] == 1'b0, "R5 idle before", v, 0);
        fork
            ext_send({1'b0, 8'hA5}, 9);
            begin repeat (40) @(negedge clk); rd(2'd2, vb); end
        join
        check(vb[1:0] == 2'b01, "R5 busy mid-char", vb, 1);
        rd(2'd2, v); check(v == 8'h02, "R5 R6 busy clear full set", v, 2);
        rd(2'd3, v); check(v == 8'hA5, "R4 even good data", v, 8'hA5);
    endtask

    task automatic t_seven();
        logic [7:0] v;
        wr(2'd0, 8'h31);
        ext_send({2'b01, 7'h53}, 8);
        rd(2'd2, v); check(v == 8'h02, "R4 odd parity ok", v, 2);
        rd(2'd3, v); check(v == 8'h53, "R3 bit7 zero", v, 8'h53);
    endtask

    task automatic t_parity_err();
        logic [7:0] v;
        wr(2'd0, 8'h19);
        ext_send({1'b1, 8'hA5}, 9);
        rd(2'd2, v); check(v == 8'h06, "R4 parity error flagged", v, 6);
        rd(2'd3, v); check(v == 8'hA5, "R4 data kept", v, 8'hA5);
        rd(2'd2, v); check(v == 8'h00, "R4 perr cleared by read", v, 0);
    endtask

    task automatic t_overrun();
        logic [7:0] v;
        wr(2'd0, 8'h09);
        ext_send({1'b0, 8'h11}, 8);
        ext_send({1'b0, 8'h82}, 8);
        rd(2'd2, v); check(v == 8'h0A, "R8 overrun set", v, 8'h0A);
        rd(2'd3, v); check(v == 8'h82, "R8 overwritten", v, 8'h82);
        rd(2'd2, v); check(v == 8'h00, "R8 overrun cleared", v, 0);
    endtask

    task automatic t_rx_off();
        logic [7:0] v; int i0;
        wr(2'd0, 8'h08);
        i0 = irq_cnt;
        ext_send({1'b0, 8'hFF}, 8);
        rd(2'd2, v); check(v == 8'h00, "R12 no busy/full", v, 0);
        check(irq_cnt == i0, "R12 no irq", irq_cnt - i0, 0);
    endtask

    task automatic t_master();
        logic [7:0] v; int i0, l0, f0;
        loopb = 1'b1;
        wr(2'd1, 8'd4);
        wr(2'd0, 8'h1F);
        check(sclk_oe == 1'b1, "R9 clock enable", sclk_oe, 1);
        i0 = irq_cnt; l0 = low_cnt; f0 = fall_cnt;
        wr(2'd2, 8'hC6);
        repeat (120) @(negedge clk);
        check(fall_cnt - f0 == 9, "R9 pulse count", fall_cnt - f0, 9);
        check(low_cnt - l0 == 45, "R9 half period", low_cnt - l0, 45);
        check(irq_cnt == i0 + 1, "R7 master irq", irq_cnt - i0, 1);
        rd(2'd2, v); check(v == 8'h02, "R10 no parity error", v, 2);
        rd(2'd3, v); check(v == 8'hC6, "R10 loopback data", v, 8'hC6);
        loopb = 1'b0;
    endtask

    task automatic t_tx_ignored();
        logic [7:0] v; int f0;
        f0 = fall_cnt;
        wr(2'd0, 8'h0D);
        wr(2'd2, 8'h55);
        repeat (60) @(negedge clk);
        wr(2'd0, 8'h0B);
        wr(2'd2, 8'h55);
        repeat (60) @(negedge clk);
        check(fall_cnt == f0, "R11 no clock", fall_cnt - f0, 0);
        rd(2'd2, v); check(v == 8'h00, "R11 no activity", v, 0);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        fails++;
        $display("FAIL watchdog actual=timeout expected=finish");
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        t_reset();
        t_lsb_first();
        t_busy();
        t_seven();
        t_parity_err();
        t_overrun();
        t_rx_off();
        t_master();
        t_tx_ignored();
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule